// File: doc/BRIEF.md
# Byte-Wide CRC-8 Engine

This block computes a CRC-8 over a byte stream, one byte per clock, for the generator polynomial x^8 + x^2 + x + 1. On each accepted byte it folds the byte into the running remainder with an XOR. It then runs the polynomial division step eight times in combinational logic. This gives the same result as a 256-entry lookup indexed by (remainder XOR byte), or as a bit-serial divider that shifts the eight data bits in and then eight zero bits.

A synchronous preset loads the seed value 0xFF before a new message. Bytes are offered with a valid strobe, and the remainder is held in a register that drives the output directly. Bit order is MSB first. There is no input or output reflection and no final XOR.

The block has two control conditions and no separate state machine. The register is either loaded from the preset path (transition "seed") or from the division network (transition "absorb"). Otherwise it keeps its value (transition "hold").

Top module: `crc8_byte_engine`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the remainder register is cleared, so `crc_out` reads 0x00 after reset.
- R2: When `seed` is high at a rising edge, `crc_out` reads 0xFF from the next cycle.
- R3: When `seed` and `byte_vld` are both high in the same cycle, the seed takes priority and the byte is discarded: `crc_out` becomes 0xFF.
- R4: When `byte_vld` is high and `seed` is low, the next remainder is the remainder of ({crc XOR byte, 8'h00}) divided by 0x107, MSB first. This is equivalent to feedback from bit 7 into bits 2, 1 and 0 over eight zero shifts.
- R5: When neither `seed` nor `byte_vld` is high, `crc_out` keeps its value, whatever `byte_in` carries.
- R6: An accepted byte shows its effect on `crc_out` in the cycle that follows the accepting edge, with exactly one register of latency.
- R7: Lookup points: index 0x01 gives 0x07, index 0x02 gives 0x0E, and index 0x80 gives 0x89.
- R8: After a seed, feeding 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40 and 0x80 in that order leaves 0x3A on `crc_out`.
- R9: Chained bytes with no seed between them give the same result as a bit-serial divider that processes each byte in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed | input | 1 | Synchronous preset of the remainder to 0xFF |
| byte_vld | input | 1 | Qualifies `byte_in` for absorption |
| byte_in | input | 8 | Message byte, MSB processed first |
| crc_out | output | 8 | Registered running remainder |

## Verification
The seed and the absorb paths can both be requested in one cycle. The bench provokes this by raising `seed` and `byte_vld` together with a range of byte values, including a byte that would give a nonzero remainder if it were absorbed. It judges the outcome by requiring 0xFF on the next cycle. The bench then feeds the same byte alone and checks that the result matches the arithmetic division model. This shows that the dropped byte left no trace.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

    localparam int unsigned CRC_W = 8;

    typedef logic [CRC_W-1:0] crc_t;

    // Register load source for one clock edge.
    typedef enum logic [1:0] {
        LD_HOLD   = 2'd0,
        LD_SEED   = 2'd1,
        LD_ABSORB = 2'd2
    } load_sel_e;

endpackage

// File: rtl/crc8_div_net.sv
module crc8_div_net #(
    parameter int unsigned         W     = 8,
    parameter logic [W-1:0]        POLY  = 8'h07,
    parameter int unsigned         STEPS = 8
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] rem_out
);

    logic [W-1:0] stage [0:STEPS];

    assign stage[0] = rem_in ^ byte_in;

    // One zero-input shift of the augmented divider per stage.
    for (genvar s = 0; s < STEPS; s++) begin : g_shift
        logic fb;
        assign fb           = stage[s][W-1];
        assign stage[s+1]   = {stage[s][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign rem_out = stage[STEPS];

    // R4: the division is linear, so a zero dividend must give a zero remainder.
    always_comb begin
        if ((rem_in ^ byte_in) == '0) begin
            a_r4_zero_in_zero_out: assert (rem_out == '0);
        end
    end

endmodule

// File: rtl/crc8_state_reg.sv
module crc8_state_reg
    import crc8_pkg::*;
#(
    parameter int unsigned  W        = 8,
    parameter logic [W-1:0] SEED_VAL = 8'hFF,
    parameter logic [W-1:0] RST_VAL  = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed,
    input  logic         byte_vld,
    input  logic [W-1:0] next_rem,
    output logic [W-1:0] rem_q
);

    load_sel_e sel;

    // Seed outranks absorb.
    always_comb begin
        if (seed)          sel = LD_SEED;
        else if (byte_vld) sel = LD_ABSORB;
        else               sel = LD_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= RST_VAL;
        end else begin
            unique case (sel)
                LD_SEED:   rem_q <= SEED_VAL;
                LD_ABSORB: rem_q <= next_rem;
                LD_HOLD:   rem_q <= rem_q;
                default:   rem_q <= rem_q;
            endcase
        end
    end

    // R2 / R3: a seed request always lands the seed value, valid or not.
    a_r3_seed_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> rem_q == SEED_VAL);

    // R5: no request, no change.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed && !byte_vld) |=> $stable(rem_q));

endmodule

// File: rtl/crc8_byte_engine.sv
module crc8_byte_engine #(
    parameter int unsigned        W        = 8,
    parameter logic [W-1:0]       POLY     = 8'h07,
    parameter logic [W-1:0]       SEED_VAL = 8'hFF,
    parameter logic [W-1:0]       RST_VAL  = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         seed,
    input  logic         byte_vld,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] crc_out
);

    localparam int unsigned STEPS = W;

    logic [W-1:0] rem_q;
    logic [W-1:0] rem_next;

    crc8_div_net #(
        .W     (W),
        .POLY  (POLY),
        .STEPS (STEPS)
    ) u_div (
        .rem_in  (rem_q),
        .byte_in (byte_in),
        .rem_out (rem_next)
    );

    crc8_state_reg #(
        .W        (W),
        .SEED_VAL (SEED_VAL),
        .RST_VAL  (RST_VAL)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed     (seed),
        .byte_vld (byte_vld),
        .next_rem (rem_next),
        .rem_q    (rem_q)
    );

    assign crc_out = rem_q;

    // R4 / R6: an absorbed byte shows the network result one cycle later.
    a_r6_absorb_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !seed) |=> crc_out == $past(rem_next));

    // R1: a reset cycle leaves the reset value.
    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> crc_out == RST_VAL);

endmodule

// File: tb/crc8_byte_engine_test.sv
module crc8_byte_engine_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       seed;
    logic       byte_vld;
    logic [7:0] byte_in;
    logic [7:0] crc_out;

    int n_vec  = 0;
    int n_miss = 0;

    always #2 clk = ~clk;

    crc8_byte_engine uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed     (seed),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .crc_out  (crc_out)
    );

    // Polynomial long division of {idx, 8'h00} by 0x107.
    function automatic logic [7:0] div_model(input logic [7:0] idx);
        logic [15:0] v;
        v = {idx, 8'h00};
        for (int i = 15; i >= 8; i--) begin
            if (v[i]) v = v ^ (16'h0107 << (i - 8));
        end
        return v[7:0];
    endfunction

    // Bit-serial divider: data bits then zero bits, feedback taps 2,1,0.
    function automatic logic [7:0] serial_model(input logic [7:0] r0, input logic [7:0] d);
        logic [7:0] r;
        logic       o;
        r = r0 ^ d;
        for (int i = 0; i < 8; i++) begin
            o = r[7];
            r = {r[6:0], 1'b0};
            r[2] = r[2] ^ o;
            r[1] = r[1] ^ o;
            r[0] = r[0] ^ o;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_vec++;
        if (crc_out !== exp) begin
            n_miss++;
            $display("FAIL %s: crc_out=%02h expected=%02h", req, crc_out, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge, after the rising edge.
    task automatic cyc(input logic s, input logic v, input logic [7:0] d);
        seed     = s;
        byte_vld = v;
        byte_in  = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: crc_out=%02h expected=done", crc_out);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        logic [7:0] model;
        logic [7:0] pat [8];
        rst_n = 1'b0; seed = 1'b0; byte_vld = 1'b0; byte_in = 8'h00;
        @(negedge clk);
        cyc(1'b0, 1'b1, 8'hA5);
        check("R1", 8'h00);
        rst_n = 1'b1;

        // R7: lookup points taken from a zero remainder.
        cyc(1'b0, 1'b1, 8'h01); check("R7", 8'h07);
        rst_n = 1'b0; cyc(1'b0, 1'b0, 8'h00); rst_n = 1'b1;
        cyc(1'b0, 1'b1, 8'h02); check("R7", 8'h0E);
        rst_n = 1'b0; cyc(1'b0, 1'b0, 8'h00); rst_n = 1'b1;
        cyc(1'b0, 1'b1, 8'h80); check("R7", 8'h89);

        // R2 seed alone.
        cyc(1'b1, 1'b0, 8'h00); check("R2", 8'hFF);

        // R8 check sequence.
        pat = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80};
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, pat[i]);
        check("R8", 8'h3A);

        // R4/R6 exhaustive: every index 0xFF^d reached from a fresh seed.
        for (int d = 0; d < 256; d++) begin
            cyc(1'b1, 1'b0, 8'h00);
            cyc(1'b0, 1'b1, 8'(d));
            check("R4", div_model(8'hFF ^ 8'(d)));
        end

        // R3 collision: seed and valid together, then prove the byte left no trace.
        for (int d = 0; d < 256; d += 17) begin
            cyc(1'b1, 1'b1, 8'(d));
            check("R3", 8'hFF);
            cyc(1'b0, 1'b1, 8'(d));
            check("R3", div_model(8'hFF ^ 8'(d)));
        end

        // R5 hold while the data bus toggles.
        model = crc_out;
        for (int d = 0; d < 256; d += 5) begin
            cyc(1'b0, 1'b0, 8'(d));
            check("R5", model);
        end

        // R9 chained absorption against the bit-serial model.
        cyc(1'b1, 1'b0, 8'h00);
        model = 8'hFF;
        for (int d = 0; d < 256; d++) begin
            cyc(1'b0, 1'b1, 8'((d * 37 + 11) & 8'hFF));
            model = serial_model(model, 8'((d * 37 + 11) & 8'hFF));
            check("R9", model);
        end

        // R1 reset in mid-stream.
        rst_n = 1'b0; cyc(1'b0, 1'b1, 8'h3C); check("R1", 8'h00);
        rst_n = 1'b1;

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule